// File: doc/BRIEF.md
# Banked Cache Dirty Status Tracker

This block keeps a one-bit "cache may hold modified data" flag for a data cache. It keeps one copy for the secure world and one for the non-secure world. Stores that mark a line dirty set the flags. Completion pulses from whole-cache maintenance (clean, invalidate, or both) clear them. The two copies are updated asymmetrically. A non-secure store, or a secure store to non-secure data, sets both copies, while a secure store to secure data sets only the secure copy. Secure maintenance clears both copies, while non-secure maintenance clears only the non-secure copy.

Software reads the flag through a coprocessor-style register port. The port decodes the opcode and register fields and checks privilege and access direction. It then either returns a 32-bit word holding the flag of the requester's world, or raises an undefined-instruction indication. The response comes one cycle after the request. The cache array, per-line dirty bits and the sequencing of maintenance are outside this block.

Top module: `cdirty_tracker`

## Requirements
- R1: After reset both copies read 0 (clean), and `rspValid` and `rspUndef` are both low.
- R2: A privileged read request with `reqOp1`=0, `reqCrn`=7, `reqCrm`=10 and `reqOp2`=6 raises `rspValid` on the next cycle. Bit 0 of `rspData` carries the non-secure copy when `reqNs`=1 and the secure copy when `reqNs`=0. Bits 31:1 are 0.
- R3: A write request (`reqWrite`=1) to that register raises `rspUndef` on the next cycle, whatever the privilege, and leaves both copies unchanged.
- R4: A user-mode read (`reqPriv`=0) of that register raises `rspUndef` on the next cycle and not `rspValid`.
- R5: A request whose fields do not match that register produces neither `rspValid` nor `rspUndef`. `rspValid` and `rspUndef` are never high together.
- R6: A dirty-marking store with `storeNs`=1 sets both copies.
- R7: A dirty-marking store with `storeNs`=0 and `storeTargetNs`=1 sets both copies.
- R8: A dirty-marking store with `storeNs`=0 and `storeTargetNs`=0 sets only the secure copy.
- R9: A maintenance completion with `maintNs`=1 clears only the non-secure copy.
- R10: A maintenance completion with `maintNs`=0 clears both copies.
- R11: Without a `maintDone` pulse, changes on `maintNs` (for example a started or aborted operation) change neither copy.
- R12: When a store and a maintenance completion arrive in the same cycle, every copy that the store sets ends at 1. A copy that only the maintenance targets still clears.
- R13: A read reports the flag values held before any store or maintenance event in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| storeDirty | input | 1 | Pulse: a store marked a cache line dirty |
| storeNs | input | 1 | Core was in the non-secure world for that store |
| storeTargetNs | input | 1 | Store targeted non-secure data |
| maintDone | input | 1 | Pulse: a whole-cache maintenance operation finished and left the cache clean |
| maintNs | input | 1 | Issuing world of the maintenance operation (1 = non-secure) |
| reqValid | input | 1 | Register access request strobe |
| reqWrite | input | 1 | Access is a write |
| reqOp1 | input | 3 | First opcode field |
| reqCrn | input | 4 | Primary register number |
| reqCrm | input | 4 | Secondary register number |
| reqOp2 | input | 3 | Second opcode field |
| reqPriv | input | 1 | Requester is in a privileged mode |
| reqNs | input | 1 | Requester is in the non-secure world |
| rspValid | output | 1 | Read completed, `rspData` is valid |
| rspData | output | 32 | Read data, bit 0 is the flag |
| rspUndef | output | 1 | Access raises an undefined-instruction exception |

## Verification
A flag stuck at 0 or set in the wrong world is a hidden error. It shows at the ports only at the next privileged read from the affected world, one cycle after that request. The bench therefore reads both worlds after every store and maintenance pattern. A lost "set wins" priority looks like a cache wrongly reported clean, and only the same-cycle collision case exposes it. Decode or privilege faults show on the very next cycle as a missing or misplaced `rspValid` or `rspUndef`.

// File: rtl/cdirty_pkg.sv
package cdirty_pkg;
  localparam int NUM_WORLDS = 2;
  localparam int SEC_IDX = 0;
  localparam int NSEC_IDX = 1;

  typedef struct packed {
    logic [NUM_WORLDS-1:0] setBank;
    logic [NUM_WORLDS-1:0] clrBank;
    logic readStb;
    logic undefStb;
    logic readNs;
  } strobe_t;
endpackage

// File: rtl/cdirty_ctrl.sv
module cdirty_ctrl
  import cdirty_pkg::*;
#(
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP1_W-1:0] SEL_OP1 = 0,
  parameter logic [CRN_W-1:0] SEL_CRN = 7,
  parameter logic [CRM_W-1:0] SEL_CRM = 10,
  parameter logic [OP2_W-1:0] SEL_OP2 = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic storeDirty,
  input  logic storeNs,
  input  logic storeTargetNs,
  input  logic maintDone,
  input  logic maintNs,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [OP1_W-1:0] reqOp1,
  input  logic [CRN_W-1:0] reqCrn,
  input  logic [CRM_W-1:0] reqCrm,
  input  logic [OP2_W-1:0] reqOp2,
  input  logic reqPriv,
  input  logic reqNs,
  output strobe_t strb
);
  logic addrHit;

  always_comb begin
    addrHit = reqValid && (reqOp1 == SEL_OP1) && (reqCrn == SEL_CRN)
              && (reqCrm == SEL_CRM) && (reqOp2 == SEL_OP2);
    strb = '0;
    strb.readStb  = addrHit && !reqWrite && reqPriv;
    strb.undefStb = addrHit && (reqWrite || !reqPriv);
    strb.readNs   = reqNs;
    // any dirty-marking store reaches the secure copy
    strb.setBank[SEC_IDX]  = storeDirty;
    strb.setBank[NSEC_IDX] = storeDirty && (storeNs || storeTargetNs);
    // secure maintenance reaches both copies, non-secure only its own
    strb.clrBank[NSEC_IDX] = maintDone;
    strb.clrBank[SEC_IDX]  = maintDone && !maintNs;
  end

  // R8: a purely secure store never touches the non-secure copy
  assert_sec_store_local_R8: assert property (@(posedge clk) disable iff (!rstN)
    (storeDirty && !storeNs && !storeTargetNs) |-> !strb.setBank[NSEC_IDX]);
  // R9: non-secure maintenance never clears the secure copy
  assert_ns_maint_local_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maintDone && maintNs) |-> !strb.clrBank[SEC_IDX]);
endmodule

// File: rtl/cdirty_datapath.sv
module cdirty_datapath
  import cdirty_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  output logic rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic rspUndef
);
  logic [NUM_WORLDS-1:0] dirtyBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyBank <= '0;
    end else begin
      for (int w = 0; w < NUM_WORLDS; w++) begin
        if (strb.setBank[w])      dirtyBank[w] <= 1'b1;
        else if (strb.clrBank[w]) dirtyBank[w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspUndef <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.readStb;
      rspUndef <= strb.undefStb;
      rspData  <= strb.readStb
                  ? {{(DATA_W-1){1'b0}}, dirtyBank[strb.readNs ? NSEC_IDX : SEC_IDX]}
                  : '0;
    end
  end

  // R5: never both response kinds at once
  assert_rsp_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && rspUndef));
  // R2: upper bits of a read word are zero
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspData[DATA_W-1:1] == '0));
  // R12: a set always lands, even against a clear
  assert_set_wins_sec_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBank[SEC_IDX] |=> dirtyBank[SEC_IDX]);
  assert_set_wins_ns_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBank[NSEC_IDX] |=> dirtyBank[NSEC_IDX]);
  // R10: the non-secure copy being dirty implies the secure copy is dirty
  assert_ns_implies_sec_R10: assert property (@(posedge clk) disable iff (!rstN)
    dirtyBank[NSEC_IDX] |-> dirtyBank[SEC_IDX]);
  // R11: no event, no change
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setBank == '0 && strb.clrBank == '0) |=> $stable(dirtyBank));
endmodule

// File: rtl/cdirty_tracker.sv
module cdirty_tracker
  import cdirty_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic storeDirty,
  input  logic storeNs,
  input  logic storeTargetNs,
  input  logic maintDone,
  input  logic maintNs,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [OP1_W-1:0] reqOp1,
  input  logic [CRN_W-1:0] reqCrn,
  input  logic [CRM_W-1:0] reqCrm,
  input  logic [OP2_W-1:0] reqOp2,
  input  logic reqPriv,
  input  logic reqNs,
  output logic rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic rspUndef
);
  strobe_t strb;

  cdirty_ctrl #(
    .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .storeDirty(storeDirty), .storeNs(storeNs), .storeTargetNs(storeTargetNs),
    .maintDone(maintDone), .maintNs(maintNs),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .reqPriv(reqPriv), .reqNs(reqNs),
    .strb(strb)
  );

  cdirty_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rspValid(rspValid), .rspData(rspData), .rspUndef(rspUndef)
  );
endmodule

// File: tb/cdirty_tracker_tb.sv
module cdirty_tracker_tb;
  logic clk = 0;
  logic rstN = 0;
  logic storeDirty = 0, storeNs = 0, storeTargetNs = 0;
  logic maintDone = 0, maintNs = 0;
  logic reqValid = 0, reqWrite = 0, reqPriv = 0, reqNs = 0;
  logic [2:0] reqOp1 = 0, reqOp2 = 0;
  logic [3:0] reqCrn = 0, reqCrm = 0;
  logic rspValid, rspUndef;
  logic [31:0] rspData;
  int errors = 0;
  int checks = 0;
  bit expS = 0, expNs = 0;

  always #5 clk = ~clk;

  cdirty_tracker u_dut (
    .clk(clk), .rstN(rstN),
    .storeDirty(storeDirty), .storeNs(storeNs), .storeTargetNs(storeTargetNs),
    .maintDone(maintDone), .maintNs(maintNs),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .reqPriv(reqPriv), .reqNs(reqNs),
    .rspValid(rspValid), .rspData(rspData), .rspUndef(rspUndef)
  );

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReq(bit wr, bit priv, bit ns, bit hit);
    reqValid = 1; reqWrite = wr; reqPriv = priv; reqNs = ns;
    reqOp1 = 0; reqCrn = 7; reqCrm = hit ? 4'd10 : 4'd5; reqOp2 = 6;
  endtask

  task automatic clrReq();
    reqValid = 0; reqWrite = 0; reqPriv = 0; reqNs = 0;
  endtask

  // expected {rspValid, rspUndef, rspData}
  task automatic access(string tag, bit wr, bit priv, bit ns, bit hit, logic [33:0] exp);
    @(negedge clk); setReq(wr, priv, ns, hit);
    @(negedge clk); clrReq();
    check(tag, {rspValid, rspUndef, rspData}, exp);
  endtask

  task automatic readBoth(string tag);
    access({tag, " sec"}, 0, 1, 0, 1, {2'b10, 31'b0, expS});
    access({tag, " ns"}, 0, 1, 1, 1, {2'b10, 31'b0, expNs});
  endtask

  task automatic store(bit ns, bit tns);
    @(negedge clk); storeDirty = 1; storeNs = ns; storeTargetNs = tns;
    @(negedge clk); storeDirty = 0; storeNs = 0; storeTargetNs = 0;
  endtask

  task automatic maint(bit ns);
    @(negedge clk); maintDone = 1; maintNs = ns;
    @(negedge clk); maintDone = 0; maintNs = 0;
  endtask

  task automatic testReset();
    check("R1 outputs idle", {rspValid, rspUndef, rspData}, 34'h0);
    readBoth("R1 reset clean");
  endtask

  task automatic testStores();
    store(0, 0); expS = 1; readBoth("R8 secure store");
    maint(0); expS = 0; expNs = 0; readBoth("R10 secure maint");
    store(1, 0); expS = 1; expNs = 1; readBoth("R6 ns store");
    maint(1); expNs = 0; readBoth("R9 ns maint");
    maint(0); expS = 0; readBoth("R10 clear secure");
    store(0, 1); expS = 1; expNs = 1; readBoth("R7 secure to ns data");
  endtask

  task automatic testNoPulse();
    @(negedge clk); maintNs = 1;
    @(negedge clk); maintNs = 0;
    @(negedge clk);
    readBoth("R11 no done pulse");
    maint(0); expS = 0; expNs = 0;
    @(negedge clk); maintNs = 0;
    readBoth("R11 after clear");
  endtask

  task automatic testDecode();
    access("R3 priv write", 1, 1, 0, 1, {2'b01, 32'h0});
    access("R3 user write", 1, 0, 1, 1, {2'b01, 32'h0});
    access("R4 user read", 0, 0, 0, 1, {2'b01, 32'h0});
    access("R5 miss", 0, 1, 0, 0, {2'b00, 32'h0});
    access("R5 miss write", 1, 0, 0, 0, {2'b00, 32'h0});
    store(1, 0); expS = 1; expNs = 1;
    access("R3 write no effect", 1, 1, 1, 1, {2'b01, 32'h0});
    readBoth("R3 flags kept");
    access("R2 upper zero", 0, 1, 1, 1, {2'b10, 32'h1});
  endtask

  task automatic testCollide();
    maint(0); expS = 0; expNs = 0;
    // secure store to secure data with secure maintenance
    @(negedge clk); storeDirty = 1; maintDone = 1; maintNs = 0;
    @(negedge clk); storeDirty = 0; maintDone = 0;
    expS = 1; expNs = 0; readBoth("R12 sec set vs sec clear");
    // non-secure store with non-secure maintenance
    @(negedge clk); storeDirty = 1; storeNs = 1; maintDone = 1; maintNs = 1;
    @(negedge clk); storeDirty = 0; storeNs = 0; maintDone = 0; maintNs = 0;
    expS = 1; expNs = 1; readBoth("R12 ns set vs ns clear");
  endtask

  task automatic testReadTiming();
    maint(0); expS = 0; expNs = 0;
    @(negedge clk); setReq(0, 1, 1, 1); storeDirty = 1; storeNs = 1;
    @(negedge clk); clrReq(); storeDirty = 0; storeNs = 0;
    check("R13 read before store", {rspValid, rspUndef, rspData}, {2'b10, 32'h0});
    expS = 1; expNs = 1;
    @(negedge clk); setReq(0, 1, 0, 1); maintDone = 1; maintNs = 0;
    @(negedge clk); clrReq(); maintDone = 0;
    check("R13 read before clear", {rspValid, rspUndef, rspData}, {2'b10, 32'h1});
    expS = 0; expNs = 0; readBoth("R13 after clear");
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testStores();
    testNoPulse();
    testDecode();
    testCollide();
    testReadTiming();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule